// File: doc/BRIEF.md
# Compare-Match Timer with Toggle Output

An up-counting timer that advances on cycles where a pre-selected count-clock enable is high. The count is compared with a reference value loaded from the bus. When the count equals the reference on a count cycle, three things happen at that edge: the counter goes back to zero, an output latch inverts, and an interrupt request flag is set. The interval between matches is therefore reference + 1 count-clock periods. Each full period of the latch spans two intervals.

The latch value is always driven on an internal clock output for a serial clock selector. It is also readable. An external pin carries the latch only while a separate output-enable control is 1, so the internal clock keeps running while the pin is held low. A one-cycle clear strobe restarts the timer. It zeroes the counter, the latch and the interrupt flag together, and counting continues on the next count cycle. While the run control is 0, the counter and the latch freeze.

The reference arrives over a valid/ready write port. The block never applies back-pressure: ready is held at 1 out of reset, and every cycle with valid high loads the data. There is no read path for the reference.

Top module: `cmpt_timer`

## Requirements
- R1: The reference register resets to all ones (255 for the default 8-bit width). On any cycle with `ref_wr_valid` = 1 it loads `ref_wr_data`. `ref_wr_ready` is 1 in every cycle after reset.
- R2: With `run` = 1 and `tick` = 1, the counter increments by one. If instead the count equals the reference, the counter returns to 0, `latch_q` inverts and `irq_q` becomes 1. After a clear, the first toggle therefore lands on the (reference + 1)th tick, and every later toggle follows another reference + 1 ticks. Cycles with `tick` = 0 change nothing.
- R3: `irq_q` stays 1 until a cycle with `irq_ack` = 1 or an effective clear. If a match and `irq_ack` fall on the same cycle, the flag remains 1.
- R4: `pin_out` equals `latch_q` while `pin_oe` = 1 and is 0 while `pin_oe` = 0. `clk_out` equals `latch_q` at all times, whatever the value of `pin_oe`.
- R5: A one-cycle `clr` pulse while `run` = 1 sets the counter, `latch_q` and `irq_q` to 0. Counting resumes with the next tick, so the next toggle comes after reference + 1 further ticks.
- R6: When a clear and a match fall on the same cycle, the clear wins: `latch_q` and `irq_q` are 0 afterwards.
- R7: While `run` = 0, the counter and `latch_q` hold their values, and both `tick` and `clr` are ignored.
- R8: After reset, `latch_q`, `clk_out`, `pin_out` and `irq_q` are 0, and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-clock enable, one pulse per count period |
| run | input | 1 | Timer enable; 0 freezes counter and latch |
| clr | input | 1 | One-cycle clear strobe (acts only while run = 1) |
| irq_ack | input | 1 | Software clear of the interrupt flag |
| pin_oe | input | 1 | External pin output enable |
| ref_wr_valid | input | 1 | Reference write valid |
| ref_wr_data | input | 8 | Reference write data |
| ref_wr_ready | output | 1 | Reference write ready (always 1 after reset) |
| latch_q | output | 1 | Readable output latch value |
| clk_out | output | 1 | Internal clock output to the serial clock selector |
| pin_out | output | 1 | External pin drive, latch gated by pin_oe |
| irq_q | output | 1 | Interrupt request flag |

## Verification
Two cases are hard to reach from the ports. Both need a specific event to land on the exact tick where the hidden count meets the reference: a clear on that tick, and an interrupt acknowledge on that tick. The stimulus reaches them by loading a small reference, clearing, and counting ticks one by one, so the cycle of the match is known without seeing the counter. The frozen state under `run` = 0 is checked in the same way. The counter is stopped one tick short of a match, ticks and a clear are applied, and then the toggle must appear on exactly the second tick after restart.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_WRAP = 2'd2,
    ACT_ZERO = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/cmpt_ref_reg.sv
module cmpt_ref_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  output logic [W-1:0] ref_q
);
  localparam logic [W-1:0] REF_RST = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= REF_RST;
      wr_ready <= 1'b0;
    end else begin
      wr_ready <= 1'b1;
      if (wr_valid) ref_q <= wr_data;
    end
  end
endmodule

// File: rtl/cmpt_counter.sv
module cmpt_counter
  import cmpt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         clr,
  input  logic [W-1:0] ref_q,
  output logic [W-1:0] cnt_q,
  output logic         match,
  output logic         clr_eff
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  cnt_act_e act;

  assign clr_eff = run & clr;
  assign match   = run & tick & (cnt_q == ref_q);

  always_comb begin
    if (clr_eff)          act = ACT_ZERO;
    else if (match)       act = ACT_WRAP;
    else if (run && tick) act = ACT_INC;
    else                  act = ACT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case (act)
        ACT_ZERO, ACT_WRAP: cnt_q <= '0;
        ACT_INC:            cnt_q <= cnt_q + ONE;
        default:            cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/cmpt_toggle.sv
module cmpt_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_eff,
  input  logic match,
  input  logic irq_ack,
  input  logic pin_oe,
  output logic latch_q,
  output logic irq_q,
  output logic pin_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (clr_eff) begin
      latch_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (match) latch_q <= ~latch_q;
      if (match)        irq_q <= 1'b1;
      else if (irq_ack) irq_q <= 1'b0;
    end
  end

  assign pin_out = latch_q & pin_oe;
endmodule

// File: rtl/cmpt_timer.sv
module cmpt_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         clr,
  input  logic         irq_ack,
  input  logic         pin_oe,
  input  logic         ref_wr_valid,
  input  logic [W-1:0] ref_wr_data,
  output logic         ref_wr_ready,
  output logic         latch_q,
  output logic         clk_out,
  output logic         pin_out,
  output logic         irq_q
);
  logic [W-1:0] ref_q;
  logic [W-1:0] cnt_q;
  logic         match;
  logic         clr_eff;

  cmpt_ref_reg #(.W(W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (ref_wr_valid),
    .wr_data  (ref_wr_data),
    .wr_ready (ref_wr_ready),
    .ref_q    (ref_q)
  );

  cmpt_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (tick),
    .clr     (clr),
    .ref_q   (ref_q),
    .cnt_q   (cnt_q),
    .match   (match),
    .clr_eff (clr_eff)
  );

  cmpt_toggle u_tgl (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_eff (clr_eff),
    .match   (match),
    .irq_ack (irq_ack),
    .pin_oe  (pin_oe),
    .latch_q (latch_q),
    .irq_q   (irq_q),
    .pin_out (pin_out)
  );

  assign clk_out = latch_q;
endmodule

// File: rtl/cmpt_timer_chk.sv
module cmpt_timer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         run,
  input logic         clr,
  input logic         irq_ack,
  input logic         pin_oe,
  input logic         ref_wr_valid,
  input logic [W-1:0] ref_wr_data,
  input logic [W-1:0] ref_q,
  input logic [W-1:0] cnt_q,
  input logic         latch_q,
  input logic         pin_out,
  input logic         irq_q
);
  assert_ref_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_wr_valid |=> ref_q == $past(ref_wr_data));

  assert_match_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !clr && cnt_q == ref_q) |=> (latch_q != $past(latch_q)) && irq_q && cnt_q == '0);

  assert_irq_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_ack && !(run && clr)) |=> irq_q);

  assert_pin_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && clr) |=> (cnt_q == '0) && !latch_q && !irq_q);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(latch_q) && $stable(cnt_q));
endmodule

bind cmpt_timer cmpt_timer_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .run          (run),
  .clr          (clr),
  .irq_ack      (irq_ack),
  .pin_oe       (pin_oe),
  .ref_wr_valid (ref_wr_valid),
  .ref_wr_data  (ref_wr_data),
  .ref_q        (ref_q),
  .cnt_q        (cnt_q),
  .latch_q      (latch_q),
  .pin_out      (pin_out),
  .irq_q        (irq_q)
);

// File: tb/cmpt_timer_test.sv
module cmpt_timer_test;
  localparam int CLK_P = 10;
  // vector word: [15:8] reference, [3:1] idle cycles between ticks, [0] pin_oe
  localparam logic [15:0] VEC [8] = '{
    16'h0001, 16'h0100, 16'h0203, 16'h0302,
    16'h0705, 16'h1000, 16'h2A09, 16'h6301
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, run = 1'b0, clr = 1'b0, irq_ack = 1'b0, pin_oe = 1'b0;
  logic ref_wr_valid = 1'b0;
  logic [7:0] ref_wr_data = '0;
  logic ref_wr_ready, latch_q, clk_out, pin_out, irq_q;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cmpt_timer #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .clr(clr),
    .irq_ack(irq_ack), .pin_oe(pin_oe), .ref_wr_valid(ref_wr_valid),
    .ref_wr_data(ref_wr_data), .ref_wr_ready(ref_wr_ready),
    .latch_q(latch_q), .clk_out(clk_out), .pin_out(pin_out), .irq_q(irq_q)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic wr_ref(input logic [7:0] v);
    ref_wr_valid = 1'b1; ref_wr_data = v; cyc(); ref_wr_valid = 1'b0;
  endtask

  task automatic do_clr();
    clr = 1'b1; cyc(); clr = 1'b0;
  endtask

  task automatic do_ack();
    irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R8 reset state
    chk("R8", "latch", latch_q, 0);
    chk("R8", "irq", irq_q, 0);
    chk("R8", "pin", pin_out, 0);
    chk("R8", "clk_out", clk_out, 0);
    chk("R1", "ready", ref_wr_ready, 1);

    // R1 default reference 255: toggle on the 256th tick
    run = 1'b1; pin_oe = 1'b1;
    ticks(255);
    chk("R1", "latch before 256th tick", latch_q, 0);
    do_tick();
    chk("R1", "latch after 256th tick", latch_q, 1);
    chk("R2", "irq after match", irq_q, 1);

    // vector table
    foreach (VEC[k]) begin
      logic [7:0] r;
      int gap;
      r = VEC[k][15:8];
      gap = int'(VEC[k][3:1]);
      pin_oe = VEC[k][0];
      wr_ref(r);
      do_clr();
      chk("R5", "latch after clear", latch_q, 0);
      chk("R5", "irq after clear", irq_q, 0);
      for (int i = 0; i < int'(r); i++) begin
        do_tick();
        for (int g = 0; g < gap; g++) cyc();
      end
      chk("R2", "latch one tick before match", latch_q, 0);
      chk("R2", "irq one tick before match", irq_q, 0);
      do_tick();
      chk("R2", "latch at match", latch_q, 1);
      chk("R2", "irq at match", irq_q, 1);
      chk("R4", "clk_out follows latch", clk_out, 1);
      chk("R4", "pin gated by oe", pin_out, int'(VEC[k][0]));
      do_ack();
      chk("R3", "irq after ack", irq_q, 0);
      chk("R3", "latch kept after ack", latch_q, 1);
    end

    // R2 second interval and R3 sticky flag
    pin_oe = 1'b1;
    wr_ref(8'd3);
    do_clr();
    ticks(4);
    chk("R2", "first toggle", latch_q, 1);
    ticks(3);
    chk("R2", "no toggle before 2nd interval", latch_q, 1);
    chk("R3", "irq held without ack", irq_q, 1);
    do_tick();
    chk("R2", "second toggle", latch_q, 0);
    chk("R4", "pin follows low latch", pin_out, 0);

    // R3 ack on the same cycle as a match
    wr_ref(8'd1);
    do_clr();
    do_tick();
    irq_ack = 1'b1; do_tick(); irq_ack = 1'b0;
    chk("R3", "match beats ack", irq_q, 1);
    chk("R3", "latch toggled on ack cycle", latch_q, 1);

    // R6 clear on the same cycle as a match
    do_clr();
    do_tick();
    clr = 1'b1; do_tick(); clr = 1'b0;
    chk("R6", "latch after clear+match", latch_q, 0);
    chk("R6", "irq after clear+match", irq_q, 0);
    do_tick();
    chk("R5", "no toggle on first tick after clear", latch_q, 0);
    do_tick();
    chk("R5", "toggle on second tick after clear", latch_q, 1);

    // R7 frozen while disabled
    wr_ref(8'd3);
    do_clr();
    ticks(4);
    do_ack();
    ticks(2);
    run = 1'b0;
    ticks(5);
    do_clr();
    chk("R7", "latch held while stopped", latch_q, 1);
    chk("R7", "clear ignored: irq", irq_q, 0);
    pin_oe = 1'b0;
    cyc();
    chk("R4", "pin low with oe=0", pin_out, 0);
    chk("R4", "clk_out runs with oe=0", clk_out, 1);
    run = 1'b1;
    do_tick();
    chk("R7", "count resumed, no toggle yet", latch_q, 1);
    do_tick();
    chk("R7", "toggle after resume", latch_q, 0);
    chk("R7", "irq after resume", irq_q, 1);

    // R2 idle cycles change nothing
    do_ack();
    for (int i = 0; i < 10; i++) cyc();
    chk("R2", "no tick no toggle", latch_q, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule